// File: doc/BRIEF.md
# Code Patch and Breakpoint Comparator Unit

This block sits on the processor's path to code memory and compares every access against a small set of programmed word addresses. One bank of comparators watches instruction fetches, and a smaller second bank watches literal (data) loads that read from code memory. A comparator that hits works in one of two ways. It can move the access to a slot in a separate system region, so that a fixed instruction or constant can be patched. It can also leave the access alone and raise a breakpoint request to the core, so the unit serves as hardware breakpoint logic.

The comparators and a control word are loaded through a simple synchronous write port. Each comparator holds a word address, an enable and a hit-kind bit. The control word holds a master enable and the word base of the patch area. The address path is combinational, so the final address, the remap flag and the breakpoint request all come out in the same cycle as the access strobe.

Top module: `patch_bkpt_unit`

## Requirements
- R1: After reset every comparator and the master enable are clear: `out_addr` equals `acc_addr`, and `remap_hit` and `bkpt_req` are low for any access.
- R2: A fetch (`acc_is_lit`=0) that hits an enabled instruction comparator (index 0 to 5) in remap kind drives `out_addr` = {base_word + index, acc_addr[1:0]} and raises `remap_hit`. The comparator data word is laid out as bits [31:2] word address, bit 1 kind (0 remap, 1 breakpoint) and bit 0 enable.
- R3: Literal comparators have write indices 6 and 7. They hit only on literal loads (`acc_is_lit`=1), and the instruction comparators hit only on fetches. The remap slot index for a literal comparator is its write index.
- R4: A hit on a comparator of breakpoint kind raises `bkpt_req` in the same cycle as `acc_valid`, keeps `out_addr` equal to `acc_addr` and keeps `remap_hit` low. Both bank kinds support this.
- R5: Address bits [1:0] take no part in the compare, and they carry through unchanged into a remapped address.
- R6: An access whose top three address bits are not all zero never hits and passes through unchanged, even when a comparator holds that word.
- R7: Control register index 8 holds the patch base word in bits [31:2] and the master enable in bit 0. While the master enable is 0 no comparator hits.
- R8: A comparator whose enable bit is 0 does not hit.
- R9: When several enabled comparators of the matching bank hit, the one with the lowest index decides the kind and the remap slot.
- R10: While `acc_valid` is low, `remap_hit` and `bkpt_req` are low and `out_addr` equals `acc_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 4 | Register select: 0-5 fetch comparators, 6-7 literal comparators, 8 control |
| cfg_wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | Access strobe |
| acc_is_lit | input | 1 | 1 for a literal load, 0 for an instruction fetch |
| acc_addr | input | 32 | Access byte address |
| out_addr | output | 32 | Address forwarded to memory, remapped on a remap hit |
| remap_hit | output | 1 | The current access was redirected |
| bkpt_req | output | 1 | Breakpoint request to the core |

## Verification
Directed accesses set fetch and literal loads to the same word. This separates the two banks and shows that the slot index for a literal comparator is counted past the fetch comparators. Further directed cases cover these points: two comparators holding the same word, which shows the priority order; a sub-word offset, which shows that the low bits are masked; and a word outside the code region, which shows the region gate. Random rounds reload all comparators from a small pool of words with random enables and kinds. They then issue fetches and loads, mostly to pool words and sometimes outside the code region or with the strobe low. This mixes hits, misses, breakpoint hits and priority clashes, and each result is compared with a reference model in the bench.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
   typedef enum logic {
      HIT_REMAP = 1'b0,
      HIT_BREAK = 1'b1
   } hit_kind_e;

   localparam int unsigned FLD_ENABLE = 0;
   localparam int unsigned FLD_KIND   = 1;
   localparam int unsigned FLD_MASTER = 0;
   localparam int unsigned WORD_LSB   = 2;
endpackage

// File: rtl/pbu_cfg_regs.sv
module pbu_cfg_regs
   import pbu_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned N_CMP  = 8,
   parameter int unsigned IDX_W  = 4,
   localparam int unsigned WW    = ADDR_W - WORD_LSB
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [ADDR_W-1:0]   wr_data,
   output logic [N_CMP*WW-1:0] cmp_word,
   output logic [N_CMP-1:0]    cmp_en,
   output logic [N_CMP-1:0]    cmp_kind,
   output logic [WW-1:0]       base_word,
   output logic                master_en
);

   for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_word[i*WW +: WW] <= '0;
            cmp_en[i]            <= 1'b0;
            cmp_kind[i]          <= HIT_REMAP;
         end else if (sel) begin
            cmp_word[i*WW +: WW] <= wr_data[ADDR_W-1:WORD_LSB];
            cmp_en[i]            <= wr_data[FLD_ENABLE];
            cmp_kind[i]          <= wr_data[FLD_KIND];
         end
      end
   end

   logic ctl_sel;
   assign ctl_sel = wr_en && (wr_idx == IDX_W'(N_CMP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_word <= '0;
         master_en <= 1'b0;
      end else if (ctl_sel) begin
         base_word <= wr_data[ADDR_W-1:WORD_LSB];
         master_en <= wr_data[FLD_MASTER];
      end
   end

endmodule

// File: rtl/pbu_cmp_bank.sv
module pbu_cmp_bank #(
   parameter int unsigned WW   = 30,
   parameter int unsigned N    = 6,
   localparam int unsigned LIW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [WW-1:0]   look_word,
   input  logic            look_ok,
   input  logic [N*WW-1:0] words,
   input  logic [N-1:0]    en,
   input  logic [N-1:0]    kind,
   output logic            hit,
   output logic [LIW-1:0]  hit_idx,
   output logic            hit_kind
);

   logic [N-1:0] match;

   for (genvar i = 0; i < N; i++) begin : g_match
      assign match[i] = look_ok && en[i] && (words[i*WW +: WW] == look_word);
   end

   // scan from the top so the lowest matching index is written last
   always_comb begin
      hit      = 1'b0;
      hit_idx  = '0;
      hit_kind = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit      = 1'b1;
            hit_idx  = LIW'(i);
            hit_kind = kind[i];
         end
      end
   end

endmodule

// File: rtl/patch_bkpt_unit.sv
module patch_bkpt_unit
   import pbu_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned N_INSTR     = 6,
   parameter int unsigned N_LIT       = 2,
   parameter int unsigned REGION_BITS = 3,
   localparam int unsigned N_CMP      = N_INSTR + N_LIT,
   localparam int unsigned IDX_W      = $clog2(N_CMP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [IDX_W-1:0]  cfg_wr_idx,
   input  logic [ADDR_W-1:0] cfg_wr_data,
   input  logic              acc_valid,
   input  logic              acc_is_lit,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] out_addr,
   output logic              remap_hit,
   output logic              bkpt_req
);

   localparam int unsigned WW    = ADDR_W - WORD_LSB;
   localparam int unsigned LIW_I = (N_INSTR > 1) ? $clog2(N_INSTR) : 1;
   localparam int unsigned LIW_L = (N_LIT > 1) ? $clog2(N_LIT) : 1;

   if (N_INSTR < 1) begin : g_bad_instr
      $error("patch_bkpt_unit: N_INSTR must be at least 1");
   end
   if (N_LIT < 1) begin : g_bad_lit
      $error("patch_bkpt_unit: N_LIT must be at least 1");
   end
   if (REGION_BITS < 1 || REGION_BITS >= WW) begin : g_bad_region
      $error("patch_bkpt_unit: REGION_BITS out of range");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("patch_bkpt_unit: ADDR_W too small");
   end

   logic [N_CMP*WW-1:0] cmp_word;
   logic [N_CMP-1:0]    cmp_en;
   logic [N_CMP-1:0]    cmp_kind;
   logic [WW-1:0]       base_word;
   logic                master_en;

   pbu_cfg_regs #(
      .ADDR_W (ADDR_W),
      .N_CMP  (N_CMP),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wr_idx    (cfg_wr_idx),
      .wr_data   (cfg_wr_data),
      .cmp_word  (cmp_word),
      .cmp_en    (cmp_en),
      .cmp_kind  (cmp_kind),
      .base_word (base_word),
      .master_en (master_en)
   );

   logic          in_code;
   logic          look_ok;
   logic [WW-1:0] look_word;

   assign in_code   = (acc_addr[ADDR_W-1 -: REGION_BITS] == '0);
   assign look_ok   = acc_valid && master_en && in_code;
   assign look_word = acc_addr[ADDR_W-1:WORD_LSB];

   logic             i_hit, i_kind;
   logic [LIW_I-1:0] i_idx;
   logic             l_hit, l_kind;
   logic [LIW_L-1:0] l_idx;

   pbu_cmp_bank #(
      .WW (WW),
      .N  (N_INSTR)
   ) u_fetch_bank (
      .look_word (look_word),
      .look_ok   (look_ok && !acc_is_lit),
      .words     (cmp_word[N_INSTR*WW-1:0]),
      .en        (cmp_en[N_INSTR-1:0]),
      .kind      (cmp_kind[N_INSTR-1:0]),
      .hit       (i_hit),
      .hit_idx   (i_idx),
      .hit_kind  (i_kind)
   );

   pbu_cmp_bank #(
      .WW (WW),
      .N  (N_LIT)
   ) u_lit_bank (
      .look_word (look_word),
      .look_ok   (look_ok && acc_is_lit),
      .words     (cmp_word[N_CMP*WW-1:N_INSTR*WW]),
      .en        (cmp_en[N_CMP-1:N_INSTR]),
      .kind      (cmp_kind[N_CMP-1:N_INSTR]),
      .hit       (l_hit),
      .hit_idx   (l_idx),
      .hit_kind  (l_kind)
   );

   logic             sel_hit;
   hit_kind_e        sel_kind;
   logic [IDX_W-1:0] sel_idx;
   logic [WW-1:0]    target_word;

   always_comb begin
      if (acc_is_lit) begin
         sel_hit  = l_hit;
         sel_kind = hit_kind_e'(l_kind);
         sel_idx  = IDX_W'(N_INSTR) + IDX_W'(l_idx);
      end else begin
         sel_hit  = i_hit;
         sel_kind = hit_kind_e'(i_kind);
         sel_idx  = IDX_W'(i_idx);
      end
   end

   assign target_word = base_word + WW'(sel_idx);

   always_comb begin
      out_addr  = acc_addr;
      remap_hit = 1'b0;
      bkpt_req  = 1'b0;
      if (sel_hit) begin
         if (sel_kind == HIT_REMAP) begin
            out_addr  = {target_word, acc_addr[WORD_LSB-1:0]};
            remap_hit = 1'b1;
         end else begin
            bkpt_req  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/pbu_checker.sv
module pbu_checker #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned REGION_BITS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [ADDR_W-1:0] out_addr,
   input logic              remap_hit,
   input logic              bkpt_req
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!remap_hit && !bkpt_req && out_addr == acc_addr)); // R10

   AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(remap_hit && bkpt_req)); // R4

   AST_BREAK_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_req |-> out_addr == acc_addr); // R4

   AST_REGION_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_addr[ADDR_W-1 -: REGION_BITS] != '0) |->
         (!remap_hit && !bkpt_req && out_addr == acc_addr)); // R6

   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      remap_hit |-> out_addr[1:0] == acc_addr[1:0]); // R5

   AST_MISS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      !remap_hit |-> out_addr == acc_addr); // R2

endmodule

bind patch_bkpt_unit pbu_checker #(
   .ADDR_W      (ADDR_W),
   .REGION_BITS (REGION_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_addr  (acc_addr),
   .out_addr  (out_addr),
   .remap_hit (remap_hit),
   .bkpt_req  (bkpt_req)
);

// File: tb/patch_bkpt_unit_tb.sv
module patch_bkpt_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [3:0]  cfg_wr_idx = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        acc_valid = 1'b0;
   logic        acc_is_lit = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [31:0] out_addr;
   logic        remap_hit;
   logic        bkpt_req;

   always #4 clk = ~clk;

   patch_bkpt_unit u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr_en   (cfg_wr_en),
      .cfg_wr_idx  (cfg_wr_idx),
      .cfg_wr_data (cfg_wr_data),
      .acc_valid   (acc_valid),
      .acc_is_lit  (acc_is_lit),
      .acc_addr    (acc_addr),
      .out_addr    (out_addr),
      .remap_hit   (remap_hit),
      .bkpt_req    (bkpt_req)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [29:0] sh_word [8];
   logic        sh_en   [8];
   logic        sh_kind [8];
   logic [29:0] sh_base;
   logic        sh_glb;

   function automatic logic [33:0] model(logic v, logic lit, logic [31:0] a);
      logic [33:0] r;
      r = {2'b00, a};
      if (v && sh_glb && a[31:29] == 3'b000) begin
         for (int i = 0; i < 8; i++) begin
            if (((i >= 6) == lit) && sh_en[i] && sh_word[i] == a[31:2]) begin
               if (sh_kind[i]) r = {2'b10, a};
               else            r = {2'b01, sh_base + 30'(i), a[1:0]};
               break;
            end
         end
      end
      return r;
   endfunction

   task automatic wr(input int idx, input logic [31:0] data);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_idx  = 4'(idx);
      cfg_wr_data = data;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
      if (idx < 8) begin
         sh_word[idx] = data[31:2];
         sh_kind[idx] = data[1];
         sh_en[idx]   = data[0];
      end else begin
         sh_base = data[31:2];
         sh_glb  = data[0];
      end
   endtask

   task automatic acc(input string req, input logic v, input logic lit, input logic [31:0] a);
      logic [33:0] e;
      @(negedge clk);
      acc_valid  = v;
      acc_is_lit = lit;
      acc_addr   = a;
      #1;
      e = model(v, lit, a);
      n_checks++;
      if (out_addr !== e[31:0] || remap_hit !== e[32] || bkpt_req !== e[33]) begin
         n_fail++;
         $display("FAIL %s: addr=%h lit=%b v=%b got out=%h hit=%b bkpt=%b exp out=%h hit=%b bkpt=%b",
                  req, a, lit, v, out_addr, remap_hit, bkpt_req, e[31:0], e[32], e[33]);
      end
   endtask

   function automatic logic [31:0] pool(int k);
      case (k)
         0: return 32'h0000_0100;
         1: return 32'h0000_0104;
         2: return 32'h0400_0000;
         default: return 32'h1FFF_FFFC;
      endcase
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) begin
         sh_word[i] = '0; sh_en[i] = 1'b0; sh_kind[i] = 1'b0;
      end
      sh_base = '0;
      sh_glb  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: nothing hits out of reset, even at address zero
      acc("R1", 1'b1, 1'b0, 32'h0000_0000);
      acc("R1", 1'b1, 1'b1, 32'h0000_0100);

      wr(8, 32'hE000_0001);             // base 0xE0000000, master on (R7)
      wr(2, 32'h0000_0101);             // fetch comp 2 @0x100 remap
      acc("R2", 1'b1, 1'b0, 32'h0000_0100);
      acc("R5", 1'b1, 1'b0, 32'h0000_0102);   // expect 0xE000000A

      wr(6, 32'h0000_0101);             // literal comp 6 @0x100 remap
      acc("R3", 1'b1, 1'b1, 32'h0000_0103);   // expect 0xE000001B
      wr(3, 32'h0000_0201);             // fetch comp 3 @0x200
      acc("R3", 1'b1, 1'b1, 32'h0000_0200);   // literal load must miss

      wr(0, 32'h0000_0303);             // fetch comp 0 @0x300 breakpoint
      acc("R4", 1'b1, 1'b0, 32'h0000_0300);
      wr(7, 32'h0000_0403);             // literal comp 7 breakpoint
      acc("R4", 1'b1, 1'b1, 32'h0000_0401);

      wr(4, 32'h2000_0101);             // word outside code region
      acc("R6", 1'b1, 1'b0, 32'h2000_0100);

      wr(1, 32'h0000_0500);             // enable clear
      acc("R8", 1'b1, 1'b0, 32'h0000_0500);

      wr(1, 32'h0000_0601);             // comps 1 and 5 share a word
      wr(5, 32'h0000_0603);
      acc("R9", 1'b1, 1'b0, 32'h0000_0600);   // comp 1 remap wins
      wr(1, 32'h0000_0603);
      wr(5, 32'h0000_0601);
      acc("R9", 1'b1, 1'b0, 32'h0000_0600);   // comp 1 breakpoint wins

      acc("R10", 1'b0, 1'b0, 32'h0000_0100);

      wr(8, 32'hE000_0000);             // master off
      acc("R7", 1'b1, 1'b0, 32'h0000_0100);
      acc("R7", 1'b1, 1'b1, 32'h0000_0100);

      // random rounds
      for (int r = 0; r < 40; r++) begin
         for (int i = 0; i < 8; i++) begin
            logic [31:0] d;
            d = pool(int'($urandom_range(0, 3)));
            d[1] = 1'($urandom_range(0, 1));
            d[0] = ($urandom_range(0, 3) != 0);
            wr(i, d);
         end
         wr(8, {3'b111, 27'($urandom), 1'b0, ($urandom_range(0, 7) != 0)});
         for (int k = 0; k < 20; k++) begin
            logic [31:0] a;
            logic        v;
            a = pool(int'($urandom_range(0, 3)));
            a[1:0] = 2'($urandom);
            if ($urandom_range(0, 7) == 0) a[31:29] = 3'($urandom_range(1, 7));
            v = ($urandom_range(0, 7) != 0);
            acc("R2/R3/R4/R9 random", v, 1'($urandom_range(0, 1)), a);
         end
      end

      @(negedge clk);
      acc_valid = 1'b0;
      finish_run();
   end

endmodule